// File: doc/BRIEF.md
# Serial Synthesizer Configuration Port

This block receives configuration words for a fractional-N synthesizer transmitter over a three-pin serial link: a data pin, a bit clock and a load strobe. Bits enter a 24-bit shift register, most significant bit first. When the load strobe rises, the word is copied into one of four 24-bit control words. The two lowest bits of the word pick the control word.

The control word at index 1 holds the frequency divider setting. The block splits it into an integer divide value, a 12-bit fractional numerator, a VCO band select and a lock-detect precision select. It also keeps a range-error flag. The flag is set when the integer value is below its legal floor. That floor is higher when the dual-modulus 8/9 prescaler is in use. The other three control words are stored raw and exposed as they are.

The serial pins are asynchronous to the system clock. All three pass through two-flop synchronisers, and every action happens in the system clock domain. The serial link has no back-pressure: the sender must hold each pin level for at least four system clock cycles. Each transfer produces a single-cycle, one-hot load pulse that marks which control word changed.

Top module: `cfg_serial_port`

## Requirements
- R1: On each rising edge of the synchronised bit clock, the data bit enters bit 0 of a 24-bit shift register, so the bits arrive most significant first. Only the last 24 bits shifted before a load are kept.
- R2: On each rising edge of the synchronised load strobe, the shift register is copied into the control word selected by its bits 1:0 (00 selects word 0, 01 word 1, 10 word 2, 11 word 3). No other control word changes.
- R3: While the load strobe stays high, bit clock edges still shift but change no control word. Only a low-to-high transition of the load strobe causes a transfer.
- R4: Each transfer raises exactly one bit of `load_pulse` for exactly one system clock cycle, at the index of the control word written. The pulse appears in the same cycle as the new control word.
- R5: `div_int` is bits 21:14 of control word 1. `div_frac_num` is bits 13:2 of control word 1, and the fractional part of the divide ratio is `div_frac_num`/4096.
- R6: `vco_band_low` is bit 22 of control word 1. A 0 selects the 902–928 MHz band and a 1 selects the 451–464 MHz band.
- R7: `lock_prec_hi` is bit 23 of control word 1. A 0 selects the three-cycle lock-detect window and a 1 selects the five-cycle window.
- R8: When control word 1 is written, `div_range_err` becomes 1 if the integer field is below 31. If `presc_dual` is high in the transfer cycle, the threshold is 91 instead. Otherwise the flag becomes 0.
- R9: `div_range_err` changes only when control word 1 is written. Writes to words 0, 2 and 3 leave it unchanged.
- R10: While `rst_n` is low, all four control words are zero, `load_pulse` is zero and `div_range_err` is zero. This also holds for a reset in the middle of operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| cfg_sclk | input | 1 | Serial bit clock, asynchronous |
| cfg_sdata | input | 1 | Serial data, asynchronous |
| cfg_load | input | 1 | Load strobe, asynchronous, rising edge transfers |
| presc_dual | input | 1 | High when the 8/9 prescaler is in use |
| ctl_word0 | output | 24 | Control word 0, raw |
| ctl_word1 | output | 24 | Control word 1, frequency divider |
| ctl_word2 | output | 24 | Control word 2, raw |
| ctl_word3 | output | 24 | Control word 3, raw |
| load_pulse | output | 4 | One-hot single-cycle pulse per transfer |
| div_int | output | 8 | Integer divide field |
| div_frac_num | output | 12 | Fractional numerator field |
| vco_band_low | output | 1 | 1 selects the low VCO band |
| lock_prec_hi | output | 1 | 1 selects the wider lock-detect window |
| div_range_err | output | 1 | Integer field below its legal floor |

## Verification
The bench targets the range floors at both edges: 30 against 31 without the prescaler, and 90 against 91 with it. A design with an off-by-one compare, or one that ignores `presc_dual`, gives the wrong flag there. It keeps the load strobe high while a new word is shifted in. A design that transfers on level rather than on edge would overwrite a control word early. It shifts extra leading bits before a word, which exposes the wrong bit order or the wrong shift width. It also writes the raw control words between divider writes, which catches a range flag that follows any write, or a select decode that spills into a neighbouring word.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int WORD_W   = 24;
  localparam int SEL_W    = 2;
  localparam int NUM_WORD = 1 << SEL_W;
  localparam int DIV_IDX  = 1;

  localparam int INT_W    = 8;
  localparam int FRAC_W   = 12;
  localparam int FRAC_LSB = SEL_W;
  localparam int INT_LSB  = FRAC_LSB + FRAC_W;
  localparam int BAND_BIT = INT_LSB + INT_W;
  localparam int PREC_BIT = BAND_BIT + 1;

  localparam int N_FLOOR       = 31;
  localparam int N_FLOOR_PRESC = 91;

  typedef struct packed {
    logic              prec_hi;
    logic              band_low;
    logic [INT_W-1:0]  n_int;
    logic [FRAC_W-1:0] frac_num;
  } div_fields_t;

  function automatic div_fields_t split_div(input logic [WORD_W-1:0] w);
    div_fields_t f;
    f.prec_hi  = w[PREC_BIT];
    f.band_low = w[BAND_BIT];
    f.n_int    = w[INT_LSB +: INT_W];
    f.frac_num = w[FRAC_LSB +: FRAC_W];
    return f;
  endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int W = cfgport_pkg::WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_s,
  input  logic         sdata_s,
  input  logic         load_s,
  output logic [W-1:0] shreg,
  output logic         load_rise
);
  logic sclk_d;
  logic load_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      load_d <= 1'b0;
      shreg  <= '0;
    end else begin
      sclk_d <= sclk_s;
      load_d <= load_s;
      if (sclk_s && !sclk_d) begin
        shreg <= {shreg[W-2:0], sdata_s};
      end
    end
  end

  assign load_rise = load_s & ~load_d;
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank #(
  parameter int W     = cfgport_pkg::WORD_W,
  parameter int SEL_W = cfgport_pkg::SEL_W,
  localparam int N    = 1 << SEL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_rise,
  input  logic [W-1:0]        word_in,
  output logic [N-1:0][W-1:0] words,
  output logic [N-1:0]        strobe
);
  logic [SEL_W-1:0] sel;
  assign sel = word_in[SEL_W-1:0];

  for (genvar i = 0; i < N; i++) begin : g_word
    logic hit;
    assign hit = load_rise && (sel == SEL_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        words[i]  <= '0;
        strobe[i] <= 1'b0;
      end else begin
        strobe[i] <= hit;
        if (hit) begin
          words[i] <= word_in;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_div_decode.sv
module cfg_div_decode
  import cfgport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] div_word,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              presc_dual,
  output div_fields_t       fields,
  output logic              range_err
);
  div_fields_t incoming;
  logic        bad_n;

  assign fields   = split_div(div_word);
  assign incoming = split_div(wr_word);

  always_comb begin
    if (presc_dual) begin
      bad_n = (incoming.n_int < INT_W'(N_FLOOR_PRESC));
    end else begin
      bad_n = (incoming.n_int < INT_W'(N_FLOOR));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      range_err <= 1'b0;
    end else if (wr_en) begin
      range_err <= bad_n;
    end
  end
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfgport_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_sclk,
  input  logic                cfg_sdata,
  input  logic                cfg_load,
  input  logic                presc_dual,
  output logic [WORD_W-1:0]   ctl_word0,
  output logic [WORD_W-1:0]   ctl_word1,
  output logic [WORD_W-1:0]   ctl_word2,
  output logic [WORD_W-1:0]   ctl_word3,
  output logic [NUM_WORD-1:0] load_pulse,
  output logic [INT_W-1:0]    div_int,
  output logic [FRAC_W-1:0]   div_frac_num,
  output logic                vco_band_low,
  output logic                lock_prec_hi,
  output logic                div_range_err
);
  logic [2:0]                      pins_s;
  logic [WORD_W-1:0]               shreg;
  logic                            load_rise;
  logic [NUM_WORD-1:0][WORD_W-1:0] words;
  logic                            div_wr;
  div_fields_t                     fields;

  cfg_sync #(.W(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cfg_load, cfg_sdata, cfg_sclk}),
    .q     (pins_s)
  );

  cfg_shifter #(.W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (pins_s[0]),
    .sdata_s   (pins_s[1]),
    .load_s    (pins_s[2]),
    .shreg     (shreg),
    .load_rise (load_rise)
  );

  cfg_latch_bank #(.W(WORD_W), .SEL_W(SEL_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_rise (load_rise),
    .word_in   (shreg),
    .words     (words),
    .strobe    (load_pulse)
  );

  assign div_wr = load_rise && (shreg[SEL_W-1:0] == SEL_W'(DIV_IDX));

  cfg_div_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_word   (words[DIV_IDX]),
    .wr_en      (div_wr),
    .wr_word    (shreg),
    .presc_dual (presc_dual),
    .fields     (fields),
    .range_err  (div_range_err)
  );

  assign ctl_word0    = words[0];
  assign ctl_word1    = words[1];
  assign ctl_word2    = words[2];
  assign ctl_word3    = words[3];
  assign div_int      = fields.n_int;
  assign div_frac_num = fields.frac_num;
  assign vco_band_low = fields.band_low;
  assign lock_prec_hi = fields.prec_hi;
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk
  import cfgport_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                presc_dual,
  input logic [WORD_W-1:0]   ctl_word0,
  input logic [WORD_W-1:0]   ctl_word1,
  input logic [WORD_W-1:0]   ctl_word2,
  input logic [WORD_W-1:0]   ctl_word3,
  input logic [NUM_WORD-1:0] load_pulse,
  input logic [INT_W-1:0]    div_int,
  input logic                div_range_err
);
  logic [NUM_WORD-1:0][WORD_W-1:0] w;
  assign w = {ctl_word3, ctl_word2, ctl_word1, ctl_word0};

  assert_pulse_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_pulse));

  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse != '0) |=> (load_pulse == '0));

  for (genvar i = 0; i < NUM_WORD; i++) begin : g_quiet
    assert_word_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(w[i]) |-> load_pulse[i]);
  end

  assert_err_div_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_range_err) |-> load_pulse[DIV_IDX]);

  assert_err_presc_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse[DIV_IDX] && $past(presc_dual) && (div_int < INT_W'(N_FLOOR_PRESC)))
      |-> div_range_err);

  assert_err_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse[DIV_IDX] && !$past(presc_dual) && (div_int >= INT_W'(N_FLOOR)))
      |-> !div_range_err);
endmodule

bind cfg_serial_port cfg_serial_port_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .presc_dual    (presc_dual),
  .ctl_word0     (ctl_word0),
  .ctl_word1     (ctl_word1),
  .ctl_word2     (ctl_word2),
  .ctl_word3     (ctl_word3),
  .load_pulse    (load_pulse),
  .div_int       (div_int),
  .div_range_err (div_range_err)
);

// File: tb/test_cfg_serial_port.sv
module test_cfg_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_sclk = 1'b0, cfg_sdata = 1'b0, cfg_load = 1'b0, presc_dual = 1'b0;
  logic [23:0] ctl_word0, ctl_word1, ctl_word2, ctl_word3;
  logic [3:0]  load_pulse;
  logic [7:0]  div_int;
  logic [11:0] div_frac_num;
  logic        vco_band_low, lock_prec_hi, div_range_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_serial_port i_cfg_serial_port (
    .clk(clk), .rst_n(rst_n), .cfg_sclk(cfg_sclk), .cfg_sdata(cfg_sdata),
    .cfg_load(cfg_load), .presc_dual(presc_dual),
    .ctl_word0(ctl_word0), .ctl_word1(ctl_word1), .ctl_word2(ctl_word2),
    .ctl_word3(ctl_word3), .load_pulse(load_pulse), .div_int(div_int),
    .div_frac_num(div_frac_num), .vco_band_low(vco_band_low),
    .lock_prec_hi(lock_prec_hi), .div_range_err(div_range_err)
  );

  typedef struct packed {
    logic [23:0] word;
    logic        presc;
    logic        exp_err;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{ {1'b0, 1'b0, 8'd100, 12'd2048, 2'b01}, 1'b0, 1'b0 },
    '{ {1'b1, 1'b1, 8'd31,  12'd0,    2'b01}, 1'b0, 1'b0 },
    '{ {1'b0, 1'b1, 8'd30,  12'd7,    2'b01}, 1'b0, 1'b1 },
    '{ 24'hABCDE2,                             1'b0, 1'b1 },
    '{ {1'b1, 1'b0, 8'd90,  12'd1,    2'b01}, 1'b1, 1'b1 },
    '{ {1'b0, 1'b0, 8'd91,  12'd4095, 2'b01}, 1'b1, 1'b0 },
    '{ 24'h123450,                             1'b0, 1'b0 },
    '{ {1'b1, 1'b1, 8'd255, 12'd4095, 2'b01}, 1'b0, 1'b0 },
    '{ 24'hFEDCB3,                             1'b0, 1'b0 },
    '{ {1'b0, 1'b0, 8'd90,  12'd5,    2'b01}, 1'b0, 1'b0 }
  };

  int total = 0;
  int bad = 0;
  logic [23:0] model [4];
  int pulse_cnt [4];
  int pulse_len_bad = 0;
  logic [3:0] prev_pulse = '0;

  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (load_pulse[i]) pulse_cnt[i]++;
      if (load_pulse[i] && prev_pulse[i]) pulse_len_bad++;
    end
    prev_pulse = load_pulse;
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] bits, input int n);
    for (int b = n - 1; b >= 0; b--) begin
      cfg_sdata = bits[b];
      wait_clk(HOLD);
      cfg_sclk = 1'b1;
      wait_clk(HOLD);
      cfg_sclk = 1'b0;
    end
    wait_clk(HOLD);
  endtask

  task automatic clear_counts();
    for (int i = 0; i < 4; i++) pulse_cnt[i] = 0;
    pulse_len_bad = 0;
  endtask

  task automatic pulse_load();
    cfg_load = 1'b1;
    wait_clk(2 * HOLD);
    cfg_load = 1'b0;
    wait_clk(2 * HOLD);
  endtask

  task automatic check_model(input string req);
    check(req, "word0", {8'h0, ctl_word0}, {8'h0, model[0]});
    check(req, "word1", {8'h0, ctl_word1}, {8'h0, model[1]});
    check(req, "word2", {8'h0, ctl_word2}, {8'h0, model[2]});
    check(req, "word3", {8'h0, ctl_word3}, {8'h0, model[3]});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = '0;
    wait_clk(5);
    // R10: reset state
    check("R10", "reset words", {8'h0, ctl_word0 | ctl_word1 | ctl_word2 | ctl_word3}, 32'h0);
    check("R10", "reset pulse", {28'h0, load_pulse}, 32'h0);
    check("R10", "reset err", {31'h0, div_range_err}, 32'h0);
    rst_n = 1'b1;
    wait_clk(3);

    // Vector table: R1 R2 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      int sel;
      t = VECS[v];
      sel = int'(t.word[1:0]);
      presc_dual = t.presc;
      shift_bits({8'h0, t.word}, 24);
      clear_counts();
      pulse_load();
      model[sel] = t.word;
      check_model("R2");
      for (int i = 0; i < 4; i++)
        check("R4", "pulse count", pulse_cnt[i], (i == sel) ? 1 : 0);
      check("R4", "pulse width", pulse_len_bad, 0);
      check(sel == 1 ? "R8" : "R9", "range err", {31'h0, div_range_err}, {31'h0, t.exp_err});
      if (sel == 1) begin
        check("R5", "int", {24'h0, div_int}, {24'h0, t.word[21:14]});
        check("R5", "frac", {20'h0, div_frac_num}, {20'h0, t.word[13:2]});
        check("R6", "band", {31'h0, vco_band_low}, {31'h0, t.word[22]});
        check("R7", "prec", {31'h0, lock_prec_hi}, {31'h0, t.word[23]});
      end
    end
    presc_dual = 1'b0;

    // R3: load held high while a new word shifts in
    shift_bits({8'h0, 24'h5A5A56}, 24);
    clear_counts();
    cfg_load = 1'b1;
    wait_clk(2 * HOLD);
    model[2] = 24'h5A5A56;
    check("R3", "first load", {8'h0, ctl_word2}, {8'h0, model[2]});
    shift_bits({8'h0, 24'h3C3C3E}, 24);
    check_model("R3");
    check("R3", "pulse while high", pulse_cnt[2], 1);
    cfg_load = 1'b0;
    wait_clk(2 * HOLD);
    pulse_load();
    model[2] = 24'h3C3C3E;
    check("R3", "second load", {8'h0, ctl_word2}, {8'h0, model[2]});

    // R1: extra leading bits are pushed out, MSB first order kept
    shift_bits(32'hF, 4);
    shift_bits({8'h0, 24'h81_0F_F0}, 24);
    pulse_load();
    model[0] = 24'h810FF0;
    check("R1", "extra bits dropped", {8'h0, ctl_word0}, {8'h0, model[0]});

    // R10: reset in the middle of operation
    rst_n = 1'b0;
    wait_clk(2);
    check("R10", "mid reset words", {8'h0, ctl_word0 | ctl_word1 | ctl_word2 | ctl_word3}, 32'h0);
    check("R10", "mid reset err", {31'h0, div_range_err}, 32'h0);
    rst_n = 1'b1;
    wait_clk(3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule